// File: doc/BRIEF.md
# Interval Timer Read-Back Latch Unit

This block sits beside the counting core of a three-channel interval timer and serves its read-back command. Each write to the timer's control port is decoded. When the two top bits of the byte are both set, the byte is a read-back command. One such command can capture the status byte, the 16-bit count, or both, for any subset of the three channels. Any other control byte is not acted on here. It is handed on, one cycle later, to the mode-control and counter-latch logic.

Each channel presents one byte on its data port. The byte on the port is the one that a read strobe in the same cycle takes. A latched status byte is returned first. The latched count follows, in the byte order set by that channel's read/write mode. Once every pending item has been read, the port falls back to the live count.

While anything is pending on a channel, new latch commands for that channel have no effect. The data port is a register. It shows the head byte computed from the state and inputs of the previous clock edge.

Top module: `tmr_readback_unit`

## Requirements
- R1: A control write whose bits 7:6 are not 11b raises `fwd_wr` in the next cycle, with `fwd_data` equal to the written byte, and latches nothing. A write with bits 7:6 = 11b is never forwarded.
- R2: In a read-back command, bit 5 = 0 captures the live count of every selected channel, as it stands in the write cycle.
- R3: In a read-back command, bit 4 = 0 captures the status byte of every selected channel, with its bit layout unchanged.
- R4: Command bits 1, 2 and 3 select channels 0, 1 and 2. Any combination of these bits may be set in one command.
- R5: A latched value is on the channel's data port in the cycle after the command write.
- R6: When both status and count are pending on a channel, the first read returns the status byte. The count bytes follow on later reads.
- R7: The channel's read/write mode sets the count byte order. Mode 01b returns only the low byte. Mode 10b returns only the high byte. Modes 11b and 00b return the low byte and then the high byte.
- R8: While a channel has a pending status or count, a latch command for that channel has no effect. This holds for both items.
- R9: Each pending item is released by the read that returns its last byte. The port then shows the live count, in the same mode order. In the two-byte modes, the low/high pointer toggles on each live read.
- R10: A synchronous active-high reset clears every pending item and every byte pointer. While reset is asserted, all data ports and `fwd_wr` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_data | input | 8 | Control-port write byte |
| rd_stb | input | N_CH | Per-channel data-port read strobe |
| live_cnt | input | N_CH*16 | Live count of each channel, channel 0 in the low bits |
| live_sts | input | N_CH*8 | Live status byte of each channel |
| rw_mode | input | N_CH*2 | Read/write mode of each channel |
| rd_data | output | N_CH*8 | Registered data-port byte of each channel |
| fwd_wr | output | 1 | Registered strobe for a forwarded control write |
| fwd_data | output | 8 | Registered byte for the forwarded control write |

## Verification
The hardest cases to reach are a second read-back command that arrives while a channel is still partly drained, and a read strobe in the same cycle as a command. In the first case the pointer may be past the low byte. In the second, the live read and the new latch interact. The bench sweeps every control byte against rotating modes and read masks. Right after each command it changes the live values, then issues a second command, with a read strobe in the same cycle, before the channel is drained. The second command's flags and select bits differ from the first. Every port byte is compared each cycle against an arithmetic model, so both ignored latches and pointer state show up in the byte sequence.

// File: rtl/tmr_rb_pkg.sv
package tmr_rb_pkg;
  localparam int BYTE_W = 8;
  localparam int CTL_W  = 8;

  typedef enum logic [1:0] {
    RW_PAIR_ALT = 2'b00,
    RW_LO_ONLY  = 2'b01,
    RW_HI_ONLY  = 2'b10,
    RW_PAIR     = 2'b11
  } rw_mode_e;

  function automatic logic is_pair(input logic [1:0] m);
    return (m == RW_PAIR) || (m == RW_PAIR_ALT);
  endfunction
endpackage

// File: rtl/tmr_rb_decode.sv
module tmr_rb_decode
  import tmr_rb_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_data,
  output logic             cmd_hit,
  output logic             take_cnt,
  output logic             take_sts,
  output logic [N_CH-1:0]  sel,
  output logic             fwd_wr,
  output logic [CTL_W-1:0] fwd_data
);
  localparam int SEL_LSB = 1;

  assign cmd_hit  = ctl_wr && (ctl_data[7:6] == 2'b11);
  assign take_cnt = cmd_hit && !ctl_data[5];
  assign take_sts = cmd_hit && !ctl_data[4];

  for (genvar i = 0; i < N_CH; i++) begin : g_sel
    assign sel[i] = ctl_data[SEL_LSB + i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_wr   <= 1'b0;
      fwd_data <= '0;
    end else begin
      fwd_wr   <= ctl_wr && (ctl_data[7:6] != 2'b11);
      fwd_data <= ctl_data;
    end
  end

  // R1
  fwd_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_data[7:6] != 2'b11) |=> (fwd_wr && fwd_data == $past(ctl_data)));
  // R1
  rb_block_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_data[7:6] == 2'b11) |=> !fwd_wr);
endmodule

// File: rtl/tmr_rb_chan.sv
module tmr_rb_chan
  import tmr_rb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_cnt,
  input  logic              take_sts,
  input  logic              rd_stb,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic [BYTE_W-1:0] live_sts,
  input  logic [1:0]        rw_mode,
  output logic [BYTE_W-1:0] rd_data
);
  logic              sts_pend_q, sts_pend_n;
  logic              cnt_pend_q, cnt_pend_n;
  logic              hi_q, hi_n;
  logic [BYTE_W-1:0] sts_q, sts_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [CNT_W-1:0]  src;
  logic [BYTE_W-1:0] head;
  logic              blocked;

  assign blocked = sts_pend_q || cnt_pend_q;

  always_comb begin
    sts_pend_n = sts_pend_q;
    cnt_pend_n = cnt_pend_q;
    hi_n       = hi_q;
    sts_n      = sts_q;
    cnt_n      = cnt_q;
    if (rd_stb) begin
      if (sts_pend_q) begin
        sts_pend_n = 1'b0;
      end else if (cnt_pend_q) begin
        if (!is_pair(rw_mode) || hi_q) begin
          cnt_pend_n = 1'b0;
          hi_n       = 1'b0;
        end else begin
          hi_n = 1'b1;
        end
      end else if (is_pair(rw_mode)) begin
        hi_n = !hi_q;
      end
    end
    if (!blocked) begin
      if (take_cnt) begin
        cnt_pend_n = 1'b1;
        cnt_n      = live_cnt;
        hi_n       = 1'b0;
      end
      if (take_sts) begin
        sts_pend_n = 1'b1;
        sts_n      = live_sts;
      end
    end
  end

  always_comb begin
    src = cnt_pend_n ? cnt_n : live_cnt;
    if (sts_pend_n) begin
      head = sts_n;
    end else begin
      unique case (rw_mode)
        RW_LO_ONLY: head = src[BYTE_W-1:0];
        RW_HI_ONLY: head = src[2*BYTE_W-1:BYTE_W];
        default:    head = hi_n ? src[2*BYTE_W-1:BYTE_W] : src[BYTE_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_pend_q <= 1'b0;
      cnt_pend_q <= 1'b0;
      hi_q       <= 1'b0;
      sts_q      <= '0;
      cnt_q      <= '0;
      rd_data    <= '0;
    end else begin
      sts_pend_q <= sts_pend_n;
      cnt_pend_q <= cnt_pend_n;
      hi_q       <= hi_n;
      sts_q      <= sts_n;
      cnt_q      <= cnt_n;
      rd_data    <= head;
    end
  end

  // R2
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (take_cnt && !blocked) |=> (cnt_pend_q && cnt_q == $past(live_cnt)));
  // R5
  sts_show_chk: assert property (@(posedge clk) disable iff (rst)
    (take_sts && !blocked) |=> (rd_data == $past(live_sts)));
  // R8
  sts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_pend_q && take_sts) |=> $stable(sts_q));
  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_pend_q && take_cnt) |=> $stable(cnt_q));
  // R9
  cnt_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_pend_q && !rd_stb) |=> cnt_pend_q);
  // R6
  sts_first_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_pend_q && cnt_pend_q && rd_stb) |=> (cnt_pend_q && !sts_pend_q));
  // R10
  rst_clr_chk: assert property (@(posedge clk)
    rst |=> (!sts_pend_q && !cnt_pend_q && !hi_q && rd_data == '0));
endmodule

// File: rtl/tmr_readback_unit.sv
module tmr_readback_unit
  import tmr_rb_pkg::*;
#(
  parameter int N_CH  = 3,
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ctl_wr,
  input  logic [CTL_W-1:0]         ctl_data,
  input  logic [N_CH-1:0]          rd_stb,
  input  logic [N_CH*CNT_W-1:0]    live_cnt,
  input  logic [N_CH*BYTE_W-1:0]   live_sts,
  input  logic [N_CH*2-1:0]        rw_mode,
  output logic [N_CH*BYTE_W-1:0]   rd_data,
  output logic                     fwd_wr,
  output logic [CTL_W-1:0]         fwd_data
);
  logic            cmd_hit;
  logic            take_cnt;
  logic            take_sts;
  logic [N_CH-1:0] sel;

  tmr_rb_decode #(.N_CH(N_CH)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_data (ctl_data),
    .cmd_hit  (cmd_hit),
    .take_cnt (take_cnt),
    .take_sts (take_sts),
    .sel      (sel),
    .fwd_wr   (fwd_wr),
    .fwd_data (fwd_data)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tmr_rb_chan #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .take_cnt (take_cnt && sel[i]),
      .take_sts (take_sts && sel[i]),
      .rd_stb   (rd_stb[i]),
      .live_cnt (live_cnt[i*CNT_W +: CNT_W]),
      .live_sts (live_sts[i*BYTE_W +: BYTE_W]),
      .rw_mode  (rw_mode[i*2 +: 2]),
      .rd_data  (rd_data[i*BYTE_W +: BYTE_W])
    );
  end

  // R4
  sel_scope_chk: assert property (@(posedge clk) disable iff (rst)
    (take_cnt || take_sts) |-> cmd_hit);
endmodule

// File: tb/tmr_readback_unit_test.sv
`timescale 1ns/1ps
module tmr_readback_unit_test;
  localparam int N = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          ctl_wr;
  logic [7:0]    ctl_data;
  logic [N-1:0]  rd_stb;
  logic [N*16-1:0] live_cnt;
  logic [N*8-1:0]  live_sts;
  logic [N*2-1:0]  rw_mode;
  logic [N*8-1:0]  rd_data;
  logic          fwd_wr;
  logic [7:0]    fwd_data;

  always #2 clk = ~clk;

  tmr_readback_unit uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .rd_stb(rd_stb), .live_cnt(live_cnt), .live_sts(live_sts),
    .rw_mode(rw_mode), .rd_data(rd_data), .fwd_wr(fwd_wr), .fwd_data(fwd_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic        m_sp [N];
  logic        m_cp [N];
  logic        m_hi [N];
  logic [7:0]  m_sq [N];
  logic [15:0] m_cq [N];
  logic        e_fwd;
  logic [7:0]  e_fwd_data;
  logic        e_rst;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pair_m(input logic [1:0] m);
    return (m == 2'b11) || (m == 2'b00);
  endfunction

  // Expected port byte: status first (R6), then the pending count, then live (R9), order per mode (R7)
  function automatic logic [7:0] m_head(input int i);
    logic [15:0] s;
    logic [1:0]  m;
    m = rw_mode[i*2 +: 2];
    if (m_sp[i]) return m_sq[i];
    s = m_cp[i] ? m_cq[i] : live_cnt[i*16 +: 16];
    if (m == 2'b01) return s[7:0];
    if (m == 2'b10) return s[15:8];
    return m_hi[i] ? s[15:8] : s[7:0];
  endfunction

  task automatic model_edge();
    logic hit;
    logic lc;
    logic ls;
    logic blk;
    hit = ctl_wr && (ctl_data[7:6] == 2'b11);
    e_rst      = rst;
    e_fwd      = !rst && ctl_wr && (ctl_data[7:6] != 2'b11);
    e_fwd_data = rst ? 8'h00 : ctl_data;
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        m_sp[i] = 0; m_cp[i] = 0; m_hi[i] = 0; m_sq[i] = 0; m_cq[i] = 0;
      end else begin
        // R4: bit 1+i selects channel i; R2/R3 active-low flags
        lc  = hit && !ctl_data[5] && ctl_data[1+i];
        ls  = hit && !ctl_data[4] && ctl_data[1+i];
        blk = m_sp[i] || m_cp[i];
        if (rd_stb[i]) begin
          if (m_sp[i]) m_sp[i] = 0;
          else if (m_cp[i]) begin
            if (!pair_m(rw_mode[i*2 +: 2]) || m_hi[i]) begin m_cp[i] = 0; m_hi[i] = 0; end
            else m_hi[i] = 1;
          end else if (pair_m(rw_mode[i*2 +: 2])) m_hi[i] = !m_hi[i];
        end
        // R8: latches only when nothing is pending
        if (!blk) begin
          if (lc) begin m_cp[i] = 1; m_cq[i] = live_cnt[i*16 +: 16]; m_hi[i] = 0; end
          if (ls) begin m_sp[i] = 1; m_sq[i] = live_sts[i*8 +: 8]; end
        end
      end
    end
  endtask

  // one clock: inputs already driven; model follows the edge; outputs sampled at the negedge (R5)
  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      logic [7:0] e;
      string r;
      e = e_rst ? 8'h00 : m_head(i);
      r = e_rst ? "R10" : (m_sp[i] ? "R3" : (m_cp[i] ? "R7" : "R9"));
      chk(rd_data[i*8 +: 8] == e, r, {8'h00, rd_data[i*8 +: 8]}, {8'h00, e});
    end
    chk(fwd_wr == e_fwd, "R1", {15'd0, fwd_wr}, {15'd0, e_fwd});
    if (e_fwd) chk(fwd_data == e_fwd_data, "R1", {8'h00, fwd_data}, {8'h00, e_fwd_data});
  endtask

  task automatic set_live(input int seed);
    for (int i = 0; i < N; i++) begin
      live_cnt[i*16 +: 16] = 16'(seed * 601 + i * 4099 + 17);
      live_sts[i*8 +: 8]   = 8'(seed * 13 + i * 5 + 3);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1; ctl_wr = 0; ctl_data = 0; rd_stb = 0; rw_mode = '1;
    set_live(1);
    // R10: reset state
    for (int k = 0; k < 3; k++) cycle();
    rst = 0;
    cycle();
    for (int c = 0; c < 256; c++) begin
      for (int m = 0; m < 2; m++) begin
        for (int i = 0; i < N; i++) rw_mode[i*2 +: 2] = 2'((c + i + m * 3) % 4);
        set_live(c * 2 + m);
        cycle();
        // R1/R2/R3/R4: command byte c, every value swept
        ctl_wr = 1; ctl_data = 8'(c);
        cycle();
        ctl_wr = 0;
        // live moves on: latched bytes must not follow it (R2)
        set_live(c * 2 + m + 700);
        rd_stb = 3'(c + m);
        cycle();
        // R8: second command while partly drained, with a read in the same cycle
        ctl_wr = 1; ctl_data = 8'(c ^ 8'h3E); rd_stb = 3'(c >> 1);
        set_live(c + 900);
        cycle();
        ctl_wr = 0;
        for (int r = 0; r < 4; r++) begin
          rd_stb = 3'(r * 3 + c);
          cycle();
        end
        // R6/R9: drain everything, then live reads
        rd_stb = '1;
        for (int r = 0; r < 4; r++) cycle();
        rd_stb = '0;
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule